// File: doc/BRIEF.md
# Masked-Write Clock and Reset Gate Controller

This block is a small register bank on a simple memory-mapped bus. It drives a set of per-module clock-enable lines and per-module reset lines. Each control register is a 32-bit word. The upper half is a per-bit write-enable mask and the lower half carries the new values. Software can therefore flip one gate or one reset without first reading the register back.

Every control register has a read-only monitor twin at the same address plus 0x180. A monitor reports the state of its gates or resets only after the change has crossed a synchroniser into the target domain. A driver that waits on the monitor can then be sure the module has seen the change. The monitor settles a fixed three cycles after the control write, well inside any software timeout.

Top module: `cgr_gate_ctrl`

The default map has two clock registers at 0x000 and 0x004 and two reset registers at 0x080 and 0x084. Their monitors sit at 0x180, 0x184, 0x200 and 0x204. Word accesses only; byte address bits [1:0] must be zero.

## Requirements
- R1: On a write to a control register, each value bit n (bits [15:0]) whose write-enable bit n+16 is 1 takes the written value on the clock edge that samples the write.
- R2: A value bit whose write-enable bit is 0 keeps its previous state, and a register that is not written keeps its whole state.
- R3: A read of a control register returns the current values in bits [15:0] and 0 in bits [31:16].
- R4: A clock-enable value bit of 1 drives the matching `mod_clk_en` output to 1 from the cycle after the write; 0 turns it off.
- R5: A reset value bit of 0 holds the module in reset (`mod_rst` bit = 1); a value bit of 1 releases it (`mod_rst` bit = 0), from the cycle after the write.
- R6: A monitor register sits at its control address plus 0x180. Clock-monitor bits read 1 while the clock is enabled, and reset-monitor bits read 1 while the module is held in reset. Each monitor bit reflects its control bit exactly 3 clock cycles after the control bit changed: the edge that writes the control bit is cycle 0, and the new state is readable after the third edge that follows it.
- R7: After `rst_n` is asserted, all clock-enable and reset values are 0. All `mod_clk_en` outputs are 0, all `mod_rst` outputs are 1, clock monitors read 0x0000 and reset monitors read 0xFFFF.
- R8: Writes to monitor addresses and to unmapped or unaligned addresses change nothing, and reads of unmapped or unaligned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write word: mask in [31:16], values in [15:0] |
| bus_rdata | output | 32 | Read word, combinational from address |
| mod_clk_en | output | NUM_CLK_REGS*16 (32) | Per-module clock enables, register i in bits [16i+15:16i] |
| mod_rst | output | NUM_RST_REGS*16 (32) | Per-module reset, 1 = held in reset |

## Verification
The bench sweeps every value bit of every register with masks that pair the target bit with a second bit, using data that changes from step to step. A design that ignored the mask, or that shifted it by a wrong amount, would leave bits set or cleared that the model keeps. The monitor lag is checked cycle by cycle on both register kinds: one synchroniser stage too few or too many shows the new value one read early or late. The bench also writes all-zero masks, writes to monitor and unmapped addresses, makes unaligned reads, and applies a mid-run reset. These catch a design that aliases monitor addresses onto control registers, inverts the reset polarity, or leaves stale monitor state after reset.

// File: rtl/cgr_pkg.sv
package cgr_pkg;

    localparam int unsigned CGR_HALF = 16;
    localparam int unsigned CGR_WORD = 2 * CGR_HALF;

    typedef logic [CGR_HALF-1:0] cgr_half_t;
    typedef logic [CGR_WORD-1:0] cgr_word_t;

endpackage

// File: rtl/cgr_mask_reg.sv
module cgr_mask_reg #(
    parameter int unsigned W = cgr_pkg::CGR_HALF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2*W-1:0] wr_word,
    output logic [W-1:0]   val_o
);

    typedef struct packed {
        logic [W-1:0] val;
    } mreg_state_t;

    mreg_state_t  s_d, s_q;
    logic [W-1:0] wmask;
    logic [W-1:0] wval;

    assign wmask = wr_word[2*W-1:W];
    assign wval  = wr_word[W-1:0];

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.val = (s_q.val & ~wmask) | (wval & wmask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign val_o = s_q.val;

    AST_MASKED_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((val_o & $past(wmask)) == ($past(wval) & $past(wmask)))); // R1

    AST_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((val_o & ~$past(wmask)) == ($past(val_o) & ~$past(wmask)))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(val_o)); // R2

endmodule

// File: rtl/cgr_mon_sync.sv
module cgr_mon_sync #(
    parameter int unsigned W      = cgr_pkg::CGR_HALF,
    parameter int unsigned STAGES = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pipe[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            s_d.pipe[k] = s_q.pipe[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout = s_q.pipe[STAGES-1];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage_chk
        if (k == 0) begin : g_first
            AST_SYNC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
                s_q.pipe[0] == $past(din)); // R6
        end else begin : g_next
            AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
                s_q.pipe[k] == $past(s_q.pipe[k-1])); // R6
        end
    end

endmodule

// File: rtl/cgr_bus_decode.sv
module cgr_bus_decode #(
    parameter int unsigned NUM_CLK_REGS = 2,
    parameter int unsigned NUM_RST_REGS = 2,
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned CLK_BASE     = 'h000,
    parameter int unsigned RST_BASE     = 'h080,
    parameter int unsigned MON_OFFSET   = 'h180
) (
    input  logic                                  bus_sel,
    input  logic                                  bus_we,
    input  logic [ADDR_W-1:0]                     bus_addr,
    input  logic [NUM_CLK_REGS*cgr_pkg::CGR_HALF-1:0] clk_val,
    input  logic [NUM_RST_REGS*cgr_pkg::CGR_HALF-1:0] rst_val,
    input  logic [NUM_CLK_REGS*cgr_pkg::CGR_HALF-1:0] clk_mon,
    input  logic [NUM_RST_REGS*cgr_pkg::CGR_HALF-1:0] rst_mon,
    output logic [NUM_CLK_REGS-1:0]               clk_wr,
    output logic [NUM_RST_REGS-1:0]               rst_wr,
    output cgr_pkg::cgr_word_t                    rdata
);

    localparam int unsigned W = cgr_pkg::CGR_HALF;

    logic [NUM_CLK_REGS-1:0] clk_hit, clk_mon_hit;
    logic [NUM_RST_REGS-1:0] rst_hit, rst_mon_hit;

    for (genvar i = 0; i < NUM_CLK_REGS; i++) begin : g_clk_dec
        localparam int unsigned CTRL_A = CLK_BASE + 4 * i;
        assign clk_hit[i]     = (bus_addr == ADDR_W'(CTRL_A));
        assign clk_mon_hit[i] = (bus_addr == ADDR_W'(CTRL_A + MON_OFFSET));
        assign clk_wr[i]      = bus_sel & bus_we & clk_hit[i];
    end

    for (genvar i = 0; i < NUM_RST_REGS; i++) begin : g_rst_dec
        localparam int unsigned CTRL_A = RST_BASE + 4 * i;
        assign rst_hit[i]     = (bus_addr == ADDR_W'(CTRL_A));
        assign rst_mon_hit[i] = (bus_addr == ADDR_W'(CTRL_A + MON_OFFSET));
        assign rst_wr[i]      = bus_sel & bus_we & rst_hit[i];
    end

    always_comb begin
        rdata = '0;
        if (bus_sel && !bus_we) begin
            for (int i = 0; i < NUM_CLK_REGS; i++) begin
                if (clk_hit[i])     rdata = {{W{1'b0}}, clk_val[i*W +: W]};
                if (clk_mon_hit[i]) rdata = {{W{1'b0}}, clk_mon[i*W +: W]};
            end
            for (int i = 0; i < NUM_RST_REGS; i++) begin
                if (rst_hit[i])     rdata = {{W{1'b0}}, rst_val[i*W +: W]};
                if (rst_mon_hit[i]) rdata = {{W{1'b0}}, rst_mon[i*W +: W]};
            end
        end
    end

endmodule

// File: rtl/cgr_gate_ctrl.sv
module cgr_gate_ctrl #(
    parameter int unsigned NUM_CLK_REGS = 2,
    parameter int unsigned NUM_RST_REGS = 2,
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned SYNC_STAGES  = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  bus_sel,
    input  logic                                  bus_we,
    input  logic [ADDR_W-1:0]                     bus_addr,
    input  logic [31:0]                           bus_wdata,
    output logic [31:0]                           bus_rdata,
    output logic [NUM_CLK_REGS*16-1:0]            mod_clk_en,
    output logic [NUM_RST_REGS*16-1:0]            mod_rst
);

    localparam int unsigned W        = cgr_pkg::CGR_HALF;
    localparam int unsigned CLK_BITS = NUM_CLK_REGS * W;
    localparam int unsigned RST_BITS = NUM_RST_REGS * W;

    logic [CLK_BITS-1:0]     clk_val, clk_mon;
    logic [RST_BITS-1:0]     rst_val, rst_sync, rst_mon;
    logic [NUM_CLK_REGS-1:0] clk_wr;
    logic [NUM_RST_REGS-1:0] rst_wr;

    cgr_bus_decode #(
        .NUM_CLK_REGS (NUM_CLK_REGS),
        .NUM_RST_REGS (NUM_RST_REGS),
        .ADDR_W       (ADDR_W),
        .CLK_BASE     ('h000),
        .RST_BASE     ('h080),
        .MON_OFFSET   ('h180)
    ) u_decode (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .clk_val  (clk_val),
        .rst_val  (rst_val),
        .clk_mon  (clk_mon),
        .rst_mon  (rst_mon),
        .clk_wr   (clk_wr),
        .rst_wr   (rst_wr),
        .rdata    (bus_rdata)
    );

    for (genvar i = 0; i < NUM_CLK_REGS; i++) begin : g_clk_reg
        cgr_mask_reg #(.W(W)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (clk_wr[i]),
            .wr_word (bus_wdata),
            .val_o   (clk_val[i*W +: W])
        );
        cgr_mon_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (clk_val[i*W +: W]),
            .dout  (clk_mon[i*W +: W])
        );
    end

    for (genvar i = 0; i < NUM_RST_REGS; i++) begin : g_rst_reg
        cgr_mask_reg #(.W(W)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (rst_wr[i]),
            .wr_word (bus_wdata),
            .val_o   (rst_val[i*W +: W])
        );
        cgr_mon_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (rst_val[i*W +: W]),
            .dout  (rst_sync[i*W +: W])
        );
    end

    assign rst_mon    = ~rst_sync;
    assign mod_clk_en = clk_val;
    assign mod_rst    = ~rst_val;

    AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && (clk_wr == '0) && (rst_wr == '0))
        |=> ($stable(mod_clk_en) && $stable(mod_rst))); // R8

    AST_RST_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((mod_clk_en == '0) && (mod_rst == '1))); // R7

endmodule

// File: tb/cgr_gate_ctrl_bench.sv
`timescale 1ns/1ps
module cgr_gate_ctrl_bench;

    localparam int NC = 2;
    localparam int NR = 2;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC*16-1:0] mod_clk_en;
    logic [NR*16-1:0] mod_rst;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_clk [NC];
    logic [15:0] m_rst [NR];

    always #4 clk = ~clk;

    cgr_gate_ctrl #(.NUM_CLK_REGS(NC), .NUM_RST_REGS(NR), .ADDR_W(AW)) u_cgr_gate_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .mod_clk_en (mod_clk_en),
        .mod_rst    (mod_rst)
    );

    function automatic logic [AW-1:0] a_clk(input int i);
        return AW'(4 * i);
    endfunction
    function automatic logic [AW-1:0] a_rst(input int i);
        return AW'('h080 + 4 * i);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        for (int i = 0; i < NC; i++)
            if (a == a_clk(i)) m_clk[i] = (m_clk[i] & ~d[31:16]) | (d[15:0] & d[31:16]);
        for (int i = 0; i < NR; i++)
            if (a == a_rst(i)) m_rst[i] = (m_rst[i] & ~d[31:16]) | (d[15:0] & d[31:16]);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic check_all(input string tag, input bit with_mon);
        logic [31:0] d;
        for (int i = 0; i < NC; i++) begin
            rd(a_clk(i), d);           chk({tag, " R3 clk ctrl"}, d, {16'h0, m_clk[i]});
            chk({tag, " R4 clk port"}, {16'h0, mod_clk_en[i*16 +: 16]}, {16'h0, m_clk[i]});
            if (with_mon) begin
                rd(a_clk(i) + 12'h180, d); chk({tag, " R6 clk mon"}, d, {16'h0, m_clk[i]});
            end
        end
        for (int i = 0; i < NR; i++) begin
            rd(a_rst(i), d);           chk({tag, " R3 rst ctrl"}, d, {16'h0, m_rst[i]});
            chk({tag, " R5 rst port"}, {16'h0, mod_rst[i*16 +: 16]}, {16'h0, ~m_rst[i]});
            if (with_mon) begin
                rd(a_rst(i) + 12'h180, d); chk({tag, " R6 rst mon"}, d, {16'h0, ~m_rst[i]});
            end
        end
    endtask

    task automatic lag_test(input logic [AW-1:0] a, input logic [15:0] old_v,
                            input logic [15:0] new_v, input bit is_rst);
        logic [31:0] d;
        logic [15:0] o, n;
        o = is_rst ? ~old_v : old_v;
        n = is_rst ? ~new_v : new_v;
        wr(a, {16'hFFFF, new_v});
        for (int k = 0; k < 3; k++) begin
            rd(a + 12'h180, d); chk("R6 monitor still old", d, {16'h0, o});
        end
        rd(a + 12'h180, d); chk("R6 monitor settled", d, {16'h0, n});
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < NC; i++) m_clk[i] = '0;
        for (int i = 0; i < NR; i++) m_rst[i] = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check_all("R7 reset", 1'b1);

        lag_test(a_clk(0), m_clk[0], 16'hA5C3, 1'b0);
        lag_test(a_rst(1), m_rst[1], 16'h3C0F, 1'b1);

        // R1 R2 R4 R5: sweep each bit of each register with a paired mask
        for (int r = 0; r < NC + NR; r++) begin
            for (int k = 0; k < 16; k++) begin
                logic [15:0] msk, dat;
                logic [AW-1:0] a;
                msk = (16'h1 << k) | (16'h1 << ((k * 5 + 3) % 16));
                dat = 16'(k * 'h9E37) ^ 16'(r * 'h5A5A);
                a = (r < NC) ? a_clk(r) : a_rst(r - NC);
                wr(a, {msk, dat});
                rd(a, d);
                chk("R1 R2 masked write", d, {16'h0, (r < NC) ? m_clk[r] : m_rst[r - NC]});
                if (r < NC) chk("R4 clk enable port", {16'h0, mod_clk_en[r*16 +: 16]}, {16'h0, m_clk[r]});
                else        chk("R5 reset port", {16'h0, mod_rst[(r-NC)*16 +: 16]}, {16'h0, ~m_rst[r - NC]});
            end
        end
        idle(3);
        check_all("R6 after sweep", 1'b1);

        // R2: zero mask changes nothing
        for (int i = 0; i < NC; i++) wr(a_clk(i), 32'h0000_FFFF);
        for (int i = 0; i < NR; i++) wr(a_rst(i), 32'h0000_0000);
        check_all("R2 zero mask", 1'b0);

        // R3: all-ones write reads back with a zero upper half
        wr(a_clk(0), 32'hFFFF_FFFF);
        rd(a_clk(0), d); chk("R3 upper half zero", d, 32'h0000_FFFF);
        wr(a_rst(0), 32'hFFFF_FFFF);
        idle(3);

        // R8: monitor and unmapped writes ignored
        wr(a_clk(0) + 12'h180, 32'hFFFF_0000);
        wr(a_rst(0) + 12'h180, 32'hFFFF_0000);
        wr(12'h040, 32'hFFFF_0000);
        wr(12'h002, 32'hFFFF_0000);
        idle(3);
        check_all("R8 stray writes", 1'b1);
        rd(12'h040, d); chk("R8 unmapped read", d, 32'h0);
        rd(12'hFFC, d); chk("R8 unmapped read high", d, 32'h0);
        rd(12'h002, d); chk("R8 unaligned read", d, 32'h0);
        rd(12'h182, d); chk("R8 unaligned monitor read", d, 32'h0);

        // R7: mid-run reset returns everything to its default
        rst_n = 1'b0;
        idle(2);
        for (int i = 0; i < NC; i++) m_clk[i] = '0;
        for (int i = 0; i < NR; i++) m_rst[i] = '0;
        check_all("R7 mid-run reset held", 1'b1);
        rst_n = 1'b1;
        idle(1);
        check_all("R7 mid-run reset released", 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule